// File: doc/BRIEF.md
# Clock, Reset and Ready Synchronizer

This block is a processor support unit that lives entirely in the domain of one fast reference clock. It picks a timing source, either every reference cycle or the rising edges of an external frequency input, and divides that source into a processor clock (one third of the source rate, high for one source period in three), a peripheral clock (one sixth of the source rate, 50% duty) and a buffered oscillator output that toggles once per source period. All three come from a single phase counter, so the processor and peripheral clocks keep a fixed phase relationship.

The block also conditions two control paths for the processor. An active-low reset request is passed through a two-flop synchronizer that advances only on processor clock rises, and the resulting active-high processor reset is stretched so that it always lasts several processor clock cycles. Two bus-ready inputs are each qualified by their own active-low enable, merged into one ready term and registered on processor clock rises through either one or two stages, as chosen by a select input.

In this model a "processor clock rise" is the reference edge at which `cpu_clk` goes high; every synchronizer stage in the block advances only at those edges.

Top module: `clkrst_gen`

## Requirements
- R1: When `src_sel_ext` is 1 the source period is the time between rising edges of `ext_freq_in` (edge-detected after a two-flop synchronizer); when it is 0 every reference cycle is one source period.
- R2: `osc_out` toggles exactly once per source period, so with `src_sel_ext` at 0 it changes on every reference edge.
- R3: `cpu_clk` repeats every 3 source periods and is high for exactly 1 of them.
- R4: `periph_clk` toggles at exactly the edges where `cpu_clk` rises, so it repeats every 6 source periods with 3 high and 3 low.
- R5: `cpu_reset` is active high; after `rst_n_in` goes low just after a `cpu_clk` rise, `cpu_reset` is still at its old value after 2 further `cpu_clk` rises and is 1 after the 3rd.
- R6: After `rst_n_in` returns high just after a `cpu_clk` rise, `cpu_reset` remains 1 through the next 5 `cpu_clk` rises and is 0 after the 6th (a stretch of RESET_HOLD = 4 cycles beyond the synchronizer), so every processor reset pulse lasts at least 4 `cpu_clk` cycles.
- R7: The merged ready term is (`bus_rdy_a` AND NOT `rdy_a_en_n`) OR (`bus_rdy_b` AND NOT `rdy_b_en_n`); a ready input whose enable is 1 has no effect on `bus_ready`.
- R8: With `ready_one_stage` at 1, `bus_ready` shows the merged term sampled at the next `cpu_clk` rise; with it at 0 the merged term reaches `bus_ready` at the second `cpu_clk` rise, and after only one rise `bus_ready` still holds its old value.
- R9: While `sys_rst` is 1 (synchronous, active high) `cpu_clk`, `periph_clk`, `osc_out` and `bus_ready` are 0 and `cpu_reset` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock; all state changes on its rising edge |
| sys_rst | input | 1 | Synchronous active-high reset of the block state |
| ext_freq_in | input | 1 | External frequency input, used as source when selected |
| src_sel_ext | input | 1 | 1 selects the external frequency input, 0 the reference clock |
| rst_n_in | input | 1 | Active-low reset request for the processor |
| bus_rdy_a | input | 1 | First bus-ready input |
| rdy_a_en_n | input | 1 | Active-low enable qualifying `bus_rdy_a` |
| bus_rdy_b | input | 1 | Second bus-ready input |
| rdy_b_en_n | input | 1 | Active-low enable qualifying `bus_rdy_b` |
| ready_one_stage | input | 1 | 1 selects one ready synchronizer stage, 0 selects two |
| cpu_clk | output | 1 | Processor clock, source divided by 3, one-third duty |
| periph_clk | output | 1 | Peripheral clock, source divided by 6, 50% duty |
| osc_out | output | 1 | Toggles once per source period |
| cpu_reset | output | 1 | Active-high synchronized and stretched processor reset |
| bus_ready | output | 1 | Synchronized, qualified ready to the processor |

## Verification
The clock outputs react within one reference cycle of a source tick, so the bench aligns to a `cpu_clk` rise and then samples each following negative reference edge, checking the divide-by-3, divide-by-6 and toggle patterns sample by sample; with the external source it counts highs and transitions over whole 24-cycle windows so the phase of the window does not matter. The reset and ready paths are due a counted number of `cpu_clk` rises after their inputs change: the bench drives each input half a reference cycle after a rise, then steps rise by rise and samples on the following negative edge, checking the value one rise before the change is due (old value) and at the rise it is due (new value) — 3 rises for reset assertion, 6 for release, 1 or 2 for ready.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
  // Default divide ratio of the processor clock relative to the source.
  localparam int CPU_DIV_DEF    = 3;
  // Extra processor clock cycles the reset is held after the synchronizer.
  localparam int RESET_HOLD_DEF = 4;
  // Depth of the input synchronizer for the external frequency input.
  localparam int EXT_SYNC_DEF   = 2;
  // Number of ready stages in the long path.
  localparam int READY_DEPTH_DEF = 2;

  // Merge two enabled ready inputs; each enable is active low.
  function automatic logic merge_ready(input logic rdy_a, input logic en_a_n,
                                       input logic rdy_b, input logic en_b_n);
    return (rdy_a & ~en_a_n) | (rdy_b & ~en_b_n);
  endfunction
endpackage

// File: rtl/clkrst_src_pick.sv
module clkrst_src_pick #(
  parameter int EXT_SYNC = clkrst_pkg::EXT_SYNC_DEF
) (
  input  logic ref_clk,
  input  logic sys_rst,
  input  logic ext_freq_in,
  input  logic src_sel_ext,
  output logic src_tick,
  output logic osc_q
);
  localparam int SW = EXT_SYNC + 1;

  logic [SW-1:0] ext_sh;

  always_ff @(posedge ref_clk) begin
    if (sys_rst) ext_sh <= '0;
    else         ext_sh <= {ext_sh[SW-2:0], ext_freq_in};
  end

  // Rising edge of the synchronized external input, or every cycle.
  always_comb begin
    if (src_sel_ext) src_tick = ext_sh[SW-2] & ~ext_sh[SW-1];
    else             src_tick = 1'b1;
  end

  always_ff @(posedge ref_clk) begin
    if (sys_rst)       osc_q <= 1'b0;
    else if (src_tick) osc_q <= ~osc_q;
  end

  // R2: with the reference source selected the oscillator output changes every edge
  assert_osc_every_edge_R2: assert property (@(posedge ref_clk) disable iff (sys_rst)
    !src_sel_ext |=> (osc_q != $past(osc_q)));
endmodule

// File: rtl/clkrst_divider.sv
module clkrst_divider #(
  parameter int CPU_DIV = clkrst_pkg::CPU_DIV_DEF
) (
  input  logic ref_clk,
  input  logic sys_rst,
  input  logic src_tick,
  output logic cpu_clk_q,
  output logic periph_q,
  output logic cpu_rise
);
  localparam int PW = (CPU_DIV > 2) ? $clog2(CPU_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(CPU_DIV - 1);

  logic [PW-1:0] phase;
  logic          wrap;

  assign wrap     = (phase == LAST);
  // Reference edge at which the processor clock goes high.
  assign cpu_rise = src_tick & wrap;

  always_ff @(posedge ref_clk) begin
    if (sys_rst) begin
      phase     <= '0;
      cpu_clk_q <= 1'b0;
      periph_q  <= 1'b0;
    end else if (src_tick) begin
      phase     <= wrap ? '0 : phase + 1'b1;
      cpu_clk_q <= wrap;
      if (wrap) periph_q <= ~periph_q;
    end
  end

  // R3: the processor clock high phase lasts one source period only
  assert_clk_one_tick_R3: assert property (@(posedge ref_clk) disable iff (sys_rst)
    (cpu_clk_q && src_tick) |=> !cpu_clk_q);

  // R4: the peripheral clock changes exactly when the processor clock rises
  assert_periph_on_rise_R4: assert property (@(posedge ref_clk) disable iff (sys_rst)
    $rose(cpu_clk_q) == (periph_q != $past(periph_q)));
endmodule

// File: rtl/clkrst_reset_sync.sv
module clkrst_reset_sync #(
  parameter int RESET_HOLD = clkrst_pkg::RESET_HOLD_DEF
) (
  input  logic ref_clk,
  input  logic sys_rst,
  input  logic cpu_rise,
  input  logic rst_n_in,
  output logic cpu_reset
);
  localparam int CW = $clog2(RESET_HOLD + 1);
  localparam int LW = $clog2(RESET_HOLD + 3) + 1;

  logic          req_s1, req_s2;
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge ref_clk) begin
    if (sys_rst) begin
      req_s1   <= 1'b1;
      req_s2   <= 1'b1;
      hold_cnt <= CW'(RESET_HOLD);
    end else if (cpu_rise) begin
      req_s1 <= ~rst_n_in;
      req_s2 <= req_s1;
      if (req_s2)               hold_cnt <= CW'(RESET_HOLD);
      else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign cpu_reset = (hold_cnt != '0);

  // Checker: length of the current reset pulse in processor clock rises.
  logic [LW-1:0] pulse_len;
  always_ff @(posedge ref_clk) begin
    if (sys_rst)                    pulse_len <= '0;
    else if (!cpu_reset)            pulse_len <= '0;
    else if (cpu_rise && pulse_len != '1) pulse_len <= pulse_len + 1'b1;
  end

  // R6: a reset pulse never ends before RESET_HOLD processor clock cycles
  assert_reset_min_len_R6: assert property (@(posedge ref_clk) disable iff (sys_rst)
    $fell(cpu_reset) |-> (pulse_len >= LW'(RESET_HOLD)));

  // R5: the processor reset only changes on processor clock rises
  assert_reset_on_rise_R5: assert property (@(posedge ref_clk) disable iff (sys_rst)
    !$past(cpu_rise) |-> $stable(cpu_reset));
endmodule

// File: rtl/clkrst_ready_sync.sv
module clkrst_ready_sync #(
  parameter int READY_DEPTH = clkrst_pkg::READY_DEPTH_DEF
) (
  input  logic ref_clk,
  input  logic sys_rst,
  input  logic cpu_rise,
  input  logic bus_rdy_a,
  input  logic rdy_a_en_n,
  input  logic bus_rdy_b,
  input  logic rdy_b_en_n,
  input  logic ready_one_stage,
  output logic bus_ready
);
  logic                   merged;
  logic [READY_DEPTH-1:0] stage;

  assign merged = clkrst_pkg::merge_ready(bus_rdy_a, rdy_a_en_n, bus_rdy_b, rdy_b_en_n);

  always_ff @(posedge ref_clk) begin
    if (sys_rst)       stage[0] <= 1'b0;
    else if (cpu_rise) stage[0] <= merged;
  end

  for (genvar g = 1; g < READY_DEPTH; g++) begin : g_chain
    always_ff @(posedge ref_clk) begin
      if (sys_rst)       stage[g] <= 1'b0;
      else if (cpu_rise) stage[g] <= stage[g-1];
    end
  end

  assign bus_ready = ready_one_stage ? stage[0] : stage[READY_DEPTH-1];

  // R8: in one-stage mode the ready output follows the merged term after one rise
  assert_one_stage_R8: assert property (@(posedge ref_clk) disable iff (sys_rst)
    (cpu_rise && ready_one_stage) |=> (!ready_one_stage || bus_ready == $past(merged)));

  // R8: the ready output never moves between processor clock rises
  assert_ready_held_R8: assert property (@(posedge ref_clk) disable iff (sys_rst)
    (!$past(cpu_rise) && $stable(ready_one_stage)) |-> $stable(bus_ready));
endmodule

// File: rtl/clkrst_gen.sv
module clkrst_gen #(
  parameter int CPU_DIV     = clkrst_pkg::CPU_DIV_DEF,
  parameter int RESET_HOLD  = clkrst_pkg::RESET_HOLD_DEF,
  parameter int EXT_SYNC    = clkrst_pkg::EXT_SYNC_DEF,
  parameter int READY_DEPTH = clkrst_pkg::READY_DEPTH_DEF
) (
  input  logic ref_clk,
  input  logic sys_rst,
  input  logic ext_freq_in,
  input  logic src_sel_ext,
  input  logic rst_n_in,
  input  logic bus_rdy_a,
  input  logic rdy_a_en_n,
  input  logic bus_rdy_b,
  input  logic rdy_b_en_n,
  input  logic ready_one_stage,
  output logic cpu_clk,
  output logic periph_clk,
  output logic osc_out,
  output logic cpu_reset,
  output logic bus_ready
);
  logic src_tick;
  logic cpu_rise;

  clkrst_src_pick #(.EXT_SYNC(EXT_SYNC)) u_src (
    .ref_clk     (ref_clk),
    .sys_rst     (sys_rst),
    .ext_freq_in (ext_freq_in),
    .src_sel_ext (src_sel_ext),
    .src_tick    (src_tick),
    .osc_q       (osc_out)
  );

  clkrst_divider #(.CPU_DIV(CPU_DIV)) u_div (
    .ref_clk   (ref_clk),
    .sys_rst   (sys_rst),
    .src_tick  (src_tick),
    .cpu_clk_q (cpu_clk),
    .periph_q  (periph_clk),
    .cpu_rise  (cpu_rise)
  );

  clkrst_reset_sync #(.RESET_HOLD(RESET_HOLD)) u_rst (
    .ref_clk   (ref_clk),
    .sys_rst   (sys_rst),
    .cpu_rise  (cpu_rise),
    .rst_n_in  (rst_n_in),
    .cpu_reset (cpu_reset)
  );

  clkrst_ready_sync #(.READY_DEPTH(READY_DEPTH)) u_rdy (
    .ref_clk         (ref_clk),
    .sys_rst         (sys_rst),
    .cpu_rise        (cpu_rise),
    .bus_rdy_a       (bus_rdy_a),
    .rdy_a_en_n      (rdy_a_en_n),
    .bus_rdy_b       (bus_rdy_b),
    .rdy_b_en_n      (rdy_b_en_n),
    .ready_one_stage (ready_one_stage),
    .bus_ready       (bus_ready)
  );

  // R9: outputs are in their idle state during the block reset
  assert_idle_in_reset_R9: assert property (@(posedge ref_clk)
    $past(sys_rst) |-> (!cpu_clk && !periph_clk && !osc_out && cpu_reset && !bus_ready));
endmodule

// File: tb/clkrst_gen_test.sv
`timescale 1ns/1ps
module clkrst_gen_test;
  logic ref_clk = 1'b0;
  logic sys_rst = 1'b1;
  logic ext_freq_in = 1'b0;
  logic src_sel_ext = 1'b0;
  logic rst_n_in = 1'b1;
  logic bus_rdy_a = 1'b0, rdy_a_en_n = 1'b1;
  logic bus_rdy_b = 1'b0, rdy_b_en_n = 1'b1;
  logic ready_one_stage = 1'b1;
  logic cpu_clk, periph_clk, osc_out, cpu_reset, bus_ready;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit  ext_run = 1'b0;

  always #4 ref_clk = ~ref_clk;  // 125 MHz

  clkrst_gen uut (
    .ref_clk(ref_clk), .sys_rst(sys_rst), .ext_freq_in(ext_freq_in),
    .src_sel_ext(src_sel_ext), .rst_n_in(rst_n_in),
    .bus_rdy_a(bus_rdy_a), .rdy_a_en_n(rdy_a_en_n),
    .bus_rdy_b(bus_rdy_b), .rdy_b_en_n(rdy_b_en_n),
    .ready_one_stage(ready_one_stage),
    .cpu_clk(cpu_clk), .periph_clk(periph_clk), .osc_out(osc_out),
    .cpu_reset(cpu_reset), .bus_ready(bus_ready)
  );

  // Ready vectors {rdy_a, en_a_n, rdy_b, en_b_n, expected} per R7.
  localparam logic [4:0] VEC [8] = '{
    5'b1001_1, 5'b1101_0, 5'b0010_1, 5'b0111_0,
    5'b1110_1, 5'b0000_0, 5'b1010_1, 5'b0101_0
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Step to the next cpu_clk rise, then to the following negative edge.
  task automatic wait_rise();
    @(posedge cpu_clk);
    @(negedge ref_clk);
  endtask

  // External source with a period of 4 reference cycles.
  initial begin
    forever begin
      repeat (2) @(negedge ref_clk);
      if (ext_run) ext_freq_in = ~ext_freq_in;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic s_clk [25];
    logic s_pclk[25];
    logic s_osc [25];
    int   n;

    // R9: reset state
    repeat (4) @(negedge ref_clk);
    chk("R9 cpu_clk in reset",    cpu_clk,    0);
    chk("R9 periph_clk in reset", periph_clk, 0);
    chk("R9 osc_out in reset",    osc_out,    0);
    chk("R9 cpu_reset in reset",  cpu_reset,  1);
    chk("R9 bus_ready in reset",  bus_ready,  0);
    sys_rst = 1'b0;

    // R6: reset from block reset releases at the 6th rise
    for (int i = 0; i < 5; i++) wait_rise();
    chk("R6 reset held after 5 rises", cpu_reset, 1);
    wait_rise();
    chk("R6 reset low after 6 rises", cpu_reset, 0);

    // R1 R2 R3 R4: reference source
    @(posedge cpu_clk);
    for (int i = 0; i < 12; i++) begin
      @(negedge ref_clk);
      s_clk[i] = cpu_clk; s_pclk[i] = periph_clk; s_osc[i] = osc_out;
    end
    for (int i = 0; i < 12; i++) begin
      chk($sformatf("R3 cpu_clk sample %0d", i), s_clk[i], (i % 3 == 0) ? 1 : 0);
      chk($sformatf("R4 periph_clk sample %0d", i), s_pclk[i],
          ((i % 6) < 3) ? int'(s_pclk[0]) : int'(!s_pclk[0]));
      if (i > 0) chk($sformatf("R2 R1 osc toggle sample %0d", i), s_osc[i], !s_osc[i-1]);
    end

    // R1: external source, 4 reference cycles per source period
    ext_run = 1'b1;
    src_sel_ext = 1'b1;
    repeat (40) @(negedge ref_clk);
    for (int i = 0; i < 25; i++) begin
      @(negedge ref_clk);
      s_clk[i] = cpu_clk; s_pclk[i] = periph_clk; s_osc[i] = osc_out;
    end
    n = 0;
    for (int i = 0; i < 24; i++) n += s_clk[i];
    chk("R1 R3 cpu_clk high count ext", n, 8);
    n = 0;
    for (int i = 1; i < 25; i++) n += (s_osc[i] != s_osc[i-1]) ? 1 : 0;
    chk("R1 R2 osc transitions ext", n, 6);
    n = 0;
    for (int i = 1; i < 25; i++) n += (s_pclk[i] != s_pclk[i-1]) ? 1 : 0;
    chk("R1 R4 periph transitions ext", n, 2);
    n = 0;
    for (int i = 1; i < 25; i++) n += (s_clk[i] && !s_clk[i-1]) ? 1 : 0;
    chk("R1 R3 cpu_clk rises ext", n, 2);
    src_sel_ext = 1'b0;
    ext_run = 1'b0;
    repeat (10) @(negedge ref_clk);

    // R5: assertion latency
    wait_rise();
    rst_n_in = 1'b0;
    wait_rise();
    wait_rise();
    chk("R5 reset not yet after 2 rises", cpu_reset, 0);
    wait_rise();
    chk("R5 reset high after 3 rises", cpu_reset, 1);
    repeat (3) wait_rise();

    // R6: release stretch
    rst_n_in = 1'b1;
    for (int i = 0; i < 5; i++) wait_rise();
    chk("R6 reset still high after 5 rises", cpu_reset, 1);
    wait_rise();
    chk("R6 reset low after 6 rises", cpu_reset, 0);

    // R7: qualification table, one stage
    ready_one_stage = 1'b1;
    for (int v = 0; v < 8; v++) begin
      wait_rise();
      {bus_rdy_a, rdy_a_en_n, bus_rdy_b, rdy_b_en_n} = VEC[v][4:1];
      wait_rise();
      wait_rise();
      chk($sformatf("R7 vector %0d", v), bus_ready, VEC[v][0]);
    end

    // R8: latency in both modes
    bus_rdy_a = 1'b0; rdy_a_en_n = 1'b1; bus_rdy_b = 1'b0; rdy_b_en_n = 1'b1;
    ready_one_stage = 1'b0;
    repeat (3) wait_rise();
    chk("R8 two-stage settled low", bus_ready, 0);
    bus_rdy_a = 1'b1; rdy_a_en_n = 1'b0;
    wait_rise();
    chk("R8 two-stage old after 1 rise", bus_ready, 0);
    wait_rise();
    chk("R8 two-stage new after 2 rises", bus_ready, 1);
    ready_one_stage = 1'b1;
    wait_rise();
    bus_rdy_a = 1'b0;
    @(negedge ref_clk);
    chk("R8 one-stage held between rises", bus_ready, 1);
    wait_rise();
    chk("R8 one-stage new after 1 rise", bus_ready, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule